// File: doc/BRIEF.md
# Passive Parallel Configuration Loader

This block sits on the host side of a byte-wide passive configuration link. On a start request it pulls the target's configuration-reset line low for a fixed number of system cycles. It then waits for the target to release its status line. After that it streams bytes taken from a valid/ready source onto an 8-bit bus. Each byte is clocked into the target by exactly eight cycles of a configuration clock that the block derives from the system clock. No busy or ready pin is consulted: the fixed eight-clock slot is the whole pacing rule.

When the last byte has gone out, the configuration clock keeps running until the target reports configuration complete, or until a timeout counted in configuration-clock cycles expires. After completion is seen, the block waits for the target's start-up interval before it raises `done`. That interval is either a fixed time for an internal oscillator or forty periods of a user clock. If the status line drops during streaming or while waiting for completion, the block stops the clock and raises `error`. The chip selects are held active from the start of the reset pulse until the block reaches done or error.

Top module: `ppcfg_loader`

## Requirements
- R1: After reset the block drives nconfig=1, ncs=1, cs=0, dclk=0, done=0, error=0 and src_ready=0.
- R2: A one-cycle `start` pulse (accepted in idle, done or error) drives nconfig low for exactly RESET_CYC system cycles, after which nconfig returns high and stays high.
- R3: After nconfig is released, no dclk edge occurs and src_ready stays 0 for as long as nstatus is low, however long the target stretches it.
- R4: Every accepted byte is presented on cfg_data at each of exactly eight dclk rising edges, and bytes are presented in the order the source delivered them.
- R5: Each dclk high phase lasts exactly PHASE_CYC system cycles and each low phase at least PHASE_CYC, where PHASE_CYC = ceil(max(PHASE_NS, 15) / CLK_NS), so both phases are at least 15 ns.
- R6: cfg_data changes only at a clock edge where dclk was low both before and after it.
- R7: A byte is taken (src_valid and src_ready both 1 at a clock edge) only at an eight-clock slot boundary, with dclk low; while the source is empty at a boundary, dclk stays low.
- R8: ncs=0 and cs=1 from the first cycle of the reset pulse until done or error is reached; in idle, done and error ncs=1 and cs=0.
- R9: After the last byte (the one accepted with src_last=1), dclk keeps toggling until conf_done is sampled high. done then rises INIT_CYC system cycles after the edge at which conf_done was first sampled, so it is seen INIT_CYC+1 edges after conf_done is set. INIT_CYC = 40*USER_CLK_CYC when USE_USER_CLK=1, else ceil(OSC_INIT_NS / CLK_NS).
- R10: If DONE_TMO dclk cycles complete after the last byte without conf_done, error rises together with the final falling edge, and dclk then stays low.
- R11: If nstatus is low at an edge during streaming or while waiting for completion, error is set at that edge. From the following edge on, dclk is low and src_ready is 0.
- R12: done and error are never both 1. Each holds until the next `start`, and a `start` from either state begins a new reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration run (one-cycle pulse) |
| src_data | input | 8 | Byte from the bitstream source |
| src_valid | input | 1 | Source byte available |
| src_last | input | 1 | Marks the final byte of the bitstream |
| src_ready | output | 1 | Byte taken at this edge if src_valid is 1 |
| cfg_data | output | 8 | Configuration data bus to the target |
| dclk | output | 1 | Configuration clock to the target |
| nconfig | output | 1 | Active-low configuration reset to the target |
| ncs | output | 1 | Active-low chip select |
| cs | output | 1 | Active-high chip select |
| nstatus | input | 1 | Target status, low while in reset or on error |
| conf_done | input | 1 | Target reports all data received |
| done | output | 1 | Target has reached user mode |
| error | output | 1 | Status failure or completion timeout |

## Verification
The bench builds the block with CLK_NS=20 and PHASE_NS=40, so each dclk phase is two system cycles. That makes the exact high-phase width and the slot-boundary low stretch measurable. RESET_CYC=5 and DONE_TMO=6 keep the reset pulse and the completion timeout short enough to count every dclk rising edge up to the error. The user-clock start-up variant with USER_CLK_CYC=2 gives an 80-cycle wait, which lets the done latency be checked to the exact edge.

// File: rtl/ppcfg_pkg.sv
package ppcfg_pkg;

    localparam int MIN_PHASE_NS   = 15;
    localparam int SLOT_DCLKS     = 8;
    localparam int USER_INIT_MULT = 40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_WSTAT,
        ST_SEND,
        ST_WDONE,
        ST_INIT,
        ST_DONE,
        ST_ERROR
    } ld_state_e;

    typedef struct packed {
        logic nconfig;
        logic ncs;
        logic cs;
    } pins_t;

    function automatic int ceil_div(int a, int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int phase_cycles(int phase_ns, int clk_ns);
        int ns;
        int c;
        ns = (phase_ns < MIN_PHASE_NS) ? MIN_PHASE_NS : phase_ns;
        c  = ceil_div(ns, clk_ns);
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int init_cycles(bit use_user, int user_cyc, int osc_ns, int clk_ns);
        int c;
        c = use_user ? USER_INIT_MULT * user_cyc : ceil_div(osc_ns, clk_ns);
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic pins_t pins_of(ld_state_e s);
        pins_t p;
        p.nconfig = (s != ST_RESET);
        p.cs      = (s == ST_RESET) || (s == ST_WSTAT) || (s == ST_SEND) ||
                    (s == ST_WDONE) || (s == ST_INIT);
        p.ncs     = !p.cs;
        return p;
    endfunction

endpackage

// File: rtl/ppcfg_clkgen.sv
module ppcfg_clkgen #(
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic dclk,
    output logic fall_tick
);
    localparam int CW = $clog2(PHASE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick      = en && (cnt == LAST);
    assign fall_tick = tick && dclk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            dclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            dclk <= ~dclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ppcfg_timer.sv
module ppcfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && !zero) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ppcfg_seq.sv
module ppcfg_seq
    import ppcfg_pkg::*;
#(
    parameter int RESET_CYC = 50,
    parameter int DONE_TMO  = 1000,
    parameter int INIT_CYC  = 250,
    parameter int TW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [7:0]    src_data,
    input  logic          src_valid,
    input  logic          src_last,
    output logic          src_ready,
    input  logic          nstatus,
    input  logic          conf_done,
    input  logic          fall_tick,
    output logic          clk_en,
    output logic [7:0]    cfg_data,
    output ld_state_e     state,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          tmr_dec,
    input  logic          tmr_zero
);
    localparam int SW = $clog2(SLOT_DCLKS);
    localparam logic [SW-1:0] SLOT_END = SW'(SLOT_DCLKS - 1);
    localparam logic [TW-1:0] RST_LD   = TW'(RESET_CYC - 1);
    localparam logic [TW-1:0] TMO_LD   = TW'(DONE_TMO - 1);
    localparam logic [TW-1:0] INIT_LD  = TW'(INIT_CYC - 1);

    logic          active;
    logic          last_r;
    logic [SW-1:0] slot_cnt;
    logic          slot_end;
    logic          idle_like;

    assign idle_like = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_ERROR);
    assign slot_end  = active && fall_tick && (slot_cnt == SLOT_END);
    assign src_ready = (state == ST_SEND) && !active && nstatus;
    assign clk_en    = ((state == ST_SEND) && active) || (state == ST_WDONE);

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        case (state)
            ST_IDLE, ST_DONE, ST_ERROR: begin
                if (start) begin
                    tmr_load = 1'b1;
                    tmr_val  = RST_LD;
                end
            end
            ST_RESET: tmr_dec = 1'b1;
            ST_SEND: begin
                if (nstatus && slot_end && last_r) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMO_LD;
                end
            end
            ST_WDONE: begin
                if (nstatus && conf_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = INIT_LD;
                end else if (nstatus && fall_tick) begin
                    tmr_dec = 1'b1;
                end
            end
            ST_INIT: tmr_dec = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            active   <= 1'b0;
            last_r   <= 1'b0;
            slot_cnt <= '0;
            cfg_data <= '0;
        end else begin
            case (state)
                ST_RESET: if (tmr_zero) state <= ST_WSTAT;
                ST_WSTAT: if (nstatus) state <= ST_SEND;
                ST_SEND: begin
                    if (!nstatus) begin
                        state  <= ST_ERROR;
                        active <= 1'b0;
                    end else if (src_ready && src_valid) begin
                        cfg_data <= src_data;
                        last_r   <= src_last;
                        active   <= 1'b1;
                        slot_cnt <= '0;
                    end else if (active && fall_tick) begin
                        slot_cnt <= slot_cnt + 1'b1;
                        if (slot_end) begin
                            active <= 1'b0;
                            if (last_r) state <= ST_WDONE;
                        end
                    end
                end
                ST_WDONE: begin
                    if (!nstatus)                  state <= ST_ERROR;
                    else if (conf_done)            state <= ST_INIT;
                    else if (fall_tick && tmr_zero) state <= ST_ERROR;
                end
                ST_INIT: if (tmr_zero) state <= ST_DONE;
                default: begin
                    if (idle_like && start) begin
                        state  <= ST_RESET;
                        active <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ppcfg_loader.sv
module ppcfg_loader
    import ppcfg_pkg::*;
#(
    parameter int CLK_NS       = 20,
    parameter int PHASE_NS     = 20,
    parameter int RESET_CYC    = 50,
    parameter int DONE_TMO     = 1000,
    parameter bit USE_USER_CLK = 1'b0,
    parameter int USER_CLK_CYC = 4,
    parameter int OSC_INIT_NS  = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] src_data,
    input  logic       src_valid,
    input  logic       src_last,
    output logic       src_ready,
    output logic [7:0] cfg_data,
    output logic       dclk,
    output logic       nconfig,
    output logic       ncs,
    output logic       cs,
    input  logic       nstatus,
    input  logic       conf_done,
    output logic       done,
    output logic       error
);
    localparam int PHASE_CYC = phase_cycles(PHASE_NS, CLK_NS);
    localparam int INIT_CYC  = init_cycles(USE_USER_CLK, USER_CLK_CYC, OSC_INIT_NS, CLK_NS);
    localparam int TMAX      = max3(RESET_CYC, DONE_TMO, INIT_CYC);
    localparam int TW        = $clog2(TMAX + 1);

    ld_state_e     state;
    pins_t         pins;
    logic          clk_en;
    logic          fall_tick;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_dec;
    logic          tmr_zero;

    ppcfg_clkgen #(.PHASE_CYC(PHASE_CYC)) u_clkgen (
        .clk(clk), .rst(rst), .en(clk_en), .dclk(dclk), .fall_tick(fall_tick)
    );

    ppcfg_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .dec(tmr_dec), .zero(tmr_zero)
    );

    ppcfg_seq #(
        .RESET_CYC(RESET_CYC), .DONE_TMO(DONE_TMO), .INIT_CYC(INIT_CYC), .TW(TW)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .src_data(src_data), .src_valid(src_valid), .src_last(src_last),
        .src_ready(src_ready), .nstatus(nstatus), .conf_done(conf_done),
        .fall_tick(fall_tick), .clk_en(clk_en), .cfg_data(cfg_data),
        .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .tmr_dec(tmr_dec), .tmr_zero(tmr_zero)
    );

    assign pins    = pins_of(state);
    assign nconfig = pins.nconfig;
    assign ncs     = pins.ncs;
    assign cs      = pins.cs;
    assign done    = (state == ST_DONE);
    assign error   = (state == ST_ERROR);
endmodule

// File: rtl/ppcfg_loader_chk.sv
module ppcfg_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic       src_ready,
    input logic [7:0] cfg_data,
    input logic       dclk,
    input logic       nconfig,
    input logic       ncs,
    input logic       cs,
    input logic       done,
    input logic       error
);
    // R6
    data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_data) |-> (!dclk && !$past(dclk)));

    // R8
    cs_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !nconfig |-> (!ncs && cs));

    // R8
    cs_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ncs != cs);

    // R7
    accept_low_chk: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> !dclk);

    // R11
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (error && $past(error)) |-> (!dclk && !src_ready));

    // R12
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    // R8
    done_released_chk: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> (nconfig && ncs && !cs));
endmodule

bind ppcfg_loader ppcfg_loader_chk u_chk (
    .clk(clk), .rst(rst), .src_ready(src_ready), .cfg_data(cfg_data),
    .dclk(dclk), .nconfig(nconfig), .ncs(ncs), .cs(cs),
    .done(done), .error(error)
);

// File: tb/test_ppcfg_loader.sv
module test_ppcfg_loader;
    localparam int P    = 2;
    localparam int RST  = 5;
    localparam int TMO  = 6;
    localparam int INIT = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] src_data = '0;
    logic       src_valid = 1'b0;
    logic       src_last = 1'b0;
    logic       conf_done = 1'b0;
    logic       nstatus;
    logic       src_ready, dclk, nconfig, ncs, cs, done, error;
    logic [7:0] cfg_data;

    always #10 clk = ~clk;

    ppcfg_loader #(
        .CLK_NS(20), .PHASE_NS(40), .RESET_CYC(RST), .DONE_TMO(TMO),
        .USE_USER_CLK(1'b1), .USER_CLK_CYC(2), .OSC_INIT_NS(4000)
    ) i_ppcfg_loader (
        .clk(clk), .rst(rst), .start(start), .src_data(src_data),
        .src_valid(src_valid), .src_last(src_last), .src_ready(src_ready),
        .cfg_data(cfg_data), .dclk(dclk), .nconfig(nconfig), .ncs(ncs), .cs(cs),
        .nstatus(nstatus), .conf_done(conf_done), .done(done), .error(error)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // target model: status low during reset pulse, released after a stretch
    int   stretch   = 3;
    bit   force_err = 1'b0;
    int   rel_cnt   = 0;
    logic nstatus_r = 1'b1;
    assign nstatus = nstatus_r && !force_err;

    always @(negedge clk) begin
        if (!nconfig) begin
            nstatus_r <= 1'b0;
            rel_cnt   <= 0;
        end else if (!nstatus_r) begin
            if (rel_cnt >= stretch) nstatus_r <= 1'b1;
            else                    rel_cnt   <= rel_cnt + 1;
        end
    end

    // scoreboard monitor
    byte unsigned exp_q[$];
    byte unsigned cur = 0;
    logic       dclk_q = 1'b0;
    logic [7:0] data_q = '0;
    int  hilen = 0, lolen = 0, rises = 0, rib = 0;
    bit  phase_chk = 1'b0;
    bit  cs_on = 1'b0;
    bit  cs_bad = 1'b0;
    bit  data_bad = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (error) rib = 0;
            if (cfg_data != data_q && (dclk || dclk_q)) data_bad = 1'b1;
            if (cs_on && !done && !error && (ncs || !cs)) cs_bad = 1'b1;
            if (dclk && !dclk_q) begin
                rises++;
                if (rib != 0 || exp_q.size() > 0) begin
                    if (rib == 0) cur = exp_q.pop_front();
                    chk(cfg_data == cur, "R4", "byte at dclk rise", cfg_data, cur);
                    rib = (rib + 1) % 8;
                end
                if (phase_chk) chk(lolen >= P, "R5", "low phase cycles", lolen, P);
                lolen = 0;
            end
            if (!dclk && dclk_q) begin
                if (phase_chk) chk(hilen == P, "R5", "high phase cycles", hilen, P);
                hilen = 0;
            end
            if (dclk) hilen++;
            else      lolen++;
        end
        dclk_q = dclk;
        data_q = cfg_data;
    end

    // driver: pushes the expected byte, then waits for it to be taken
    task automatic send(input byte unsigned b, input bit last);
        @(negedge clk);
        src_data  = b;
        src_valid = 1'b1;
        src_last  = last;
        exp_q.push_back(b);
        while (!src_ready) @(negedge clk);
        @(negedge clk);
        src_valid = 1'b0;
        src_last  = 1'b0;
    endtask

    task automatic begin_run(input int str, output int low_cnt);
        stretch = str;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cs_on = 1'b1;
        low_cnt = 0;
        while (!nconfig) begin
            low_cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        int  lc;
        int  n;
        int  base;
        bit  ok;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(nconfig && ncs && !cs && !dclk && !done && !error && !src_ready,
            "R1", "idle outputs", {nconfig, ncs, cs, dclk, done, error, src_ready}, 7'b1100000);

        // run 1: normal configuration with stretched status
        phase_chk = 1'b1;
        begin_run(20, lc);
        chk(lc == RST, "R2", "nconfig low cycles", lc, RST);
        ok = 1'b1;
        for (int i = 0; i < 15; i++) begin
            if (dclk || src_ready || nstatus || !nconfig) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R3", "quiet while status low", ok, 1);
        send(8'hA5, 1'b0);
        send(8'h3C, 1'b0);
        send(8'h00, 1'b0);
        repeat (16 * P + 4) @(negedge clk);
        base = rises;
        ok = 1'b1;
        for (int i = 0; i < 30; i++) begin
            if (dclk) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok && rises == base, "R7", "dclk held low with empty source", rises - base, 0);
        send(8'hFF, 1'b0);
        send(8'h5A, 1'b1);
        while (exp_q.size() != 0 || rib != 0) @(negedge clk);
        base = rises;
        while (rises < base + 2) @(negedge clk);
        chk(!done && !error, "R9", "dclk runs on before conf_done", rises - base, 2);
        phase_chk = 1'b0;
        conf_done = 1'b1;
        n = 0;
        while (!done && n < INIT + 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == INIT + 1, "R9", "edges from conf_done to done", n, INIT + 1);
        chk(!error, "R12", "error clear with done", error, 0);
        chk(ncs && !cs && nconfig, "R8", "selects released in done", {ncs, cs}, 2'b10);
        chk(!cs_bad, "R8", "selects active during run", cs_bad, 0);
        cs_on = 1'b0;
        repeat (20) @(negedge clk);
        chk(done && !dclk, "R12", "done held", done, 1);

        // run 2: completion timeout, restarted from done
        conf_done = 1'b0;
        begin_run(2, lc);
        chk(lc == RST, "R12", "restart from done gives reset pulse", lc, RST);
        base = rises;
        send(8'h81, 1'b0);
        send(8'h7E, 1'b1);
        n = 0;
        while (!error && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(rises - base == 16 + TMO, "R10", "dclk rises before timeout", rises - base, 16 + TMO);
        chk(error && !done, "R10", "timeout error flag", error, 1);
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (dclk || !error) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R10", "dclk low and error held after timeout", ok, 1);
        chk(!cs_bad, "R8", "selects active during timeout run", cs_bad, 0);
        cs_on = 1'b0;

        // run 3: status failure while streaming, restarted from error
        begin_run(2, lc);
        chk(lc == RST, "R12", "restart from error gives reset pulse", lc, RST);
        send(8'h11, 1'b0);
        send(8'h22, 1'b0);
        repeat (10) @(negedge clk);
        force_err = 1'b1;
        @(negedge clk);
        chk(error, "R11", "error one edge after status drop", error, 1);
        @(negedge clk);
        chk(!dclk, "R11", "dclk stopped", dclk, 0);
        src_data  = 8'h33;
        src_valid = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (dclk || src_ready || cfg_data != 8'h22 || !error) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R11", "no clock and no byte taken after error", cfg_data, 8'h22);
        src_valid = 1'b0;
        force_err = 1'b0;
        chk(!cs_bad, "R8", "selects active during error run", cs_bad, 0);
        cs_on = 1'b0;
        chk(!data_bad, "R6", "data changed only while dclk low", data_bad, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule